// File: doc/BRIEF.md
# Console Receive Register Pair

This block presents the receive side of a system console to a processor as two registers: a status word and a received-data word. A serial receiver, which lies outside the block, hands it one character at a time through a valid/data strobe, with a separate flag for a line break. The block stores each character with its error flags and sets a ready flag. When interrupts are enabled, it raises a level interrupt request.

Software reads and writes the two registers through a simple strobed register bus. The register select is `regAddr`: 0 selects status and 1 selects data. Read data is combinational from the current state. Every side effect of an access takes place at the clock edge that ends the access cycle.

Clearing is asymmetric. A data read consumes the character: it clears the ready flag, the error bits and the request. A status write can only change the enable bit. Turning the enable bit on while a character is already waiting raises the request at once. A received break stores a fixed error word and, if allowed, pulses a halt request.

Top module: `console_rx_regs`

## Requirements
- R1: After reset, both registers read 0x0000, and `irqReq` and `haltReq` are low.
- R2: A status read shows the ready flag in bit 7 and the enable flag in bit 6, with all other bits zero. A status write changes only the enable flag, which it takes from bit 6. Writes to all other bits, including bit 7, are ignored.
- R3: A status write with bit 6 clear drops `irqReq` from the next cycle on.
- R4: A status write with bit 6 set, made while the ready flag is 1 and enable is 0, raises `irqReq` on the next cycle.
- R5: Each character arrival sets the ready flag. If enable is set, the arrival also raises `irqReq` on the next cycle.
- R6: The data word carries the character in bits 7:0, a summary error flag in bit 15, an overrun flag in bit 14, a framing flag in bit 13 and a break flag in bit 10. A data read returns all 16 bits.
- R7: Once a data read cycle ends, the ready flag is 0, `irqReq` is low, and bits 15:8 of the data word are zero. Bits 7:0 are kept.
- R8: A break arrival stores 0xA400: the summary, framing and break flags set, with character 0. If `haltEnable` is high, `haltReq` goes high for exactly one cycle. Otherwise `haltReq` stays low.
- R9: An arrival while the ready flag is still 1, with no data read in the same cycle, stores the new character with bits 15 and 14 also set.
- R10: With `sevenBit` high, the stored character is the input masked to bits 6:0.
- R11: An arrival in the same cycle as a data read stores the new character without an overrun flag, and the ready flag stays 1. The read itself returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | One-cycle strobe: a character or break has arrived |
| charData | input | 8 | Received character |
| charBreak | input | 1 | With charValid: the arrival is a line break |
| sevenBit | input | 1 | Store only bits 6:0 of the character |
| haltEnable | input | 1 | Allow a break to raise the halt request |
| regAddr | input | 1 | 0 selects status, 1 selects data |
| regRead | input | 1 | Register read strobe |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the selected register |
| irqReq | output | 1 | Level receive interrupt request |
| haltReq | output | 1 | One-cycle halt request after a permitted break |

## Verification
The bench builds the block with its default parameters: an 8-bit character in a 16-bit register, ready flag at bit 7 and enable at bit 6. With these values, the full-width and seven-bit character paths can be checked against the same table of byte patterns, including values with bit 7 set.

The directed tests cover the following collisions and sequences:
- a character arriving while the previous one is unread;
- an arrival in the same cycle as a data read;
- enable writes made while a character waits;
- break arrivals with the halt permission both on and off.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;

  typedef struct packed {
    logic loadChar;
    logic loadBreak;
    logic flagOverrun;
    logic clearErr;
  } rxStrobes_t;

endpackage

// File: rtl/con_rx_ctrl.sv
module con_rx_ctrl
  import con_rx_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int IE_POS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             charBreak,
  input  logic             haltEnable,
  input  logic             regAddr,
  input  logic             regRead,
  input  logic             regWrite,
  input  logic [REG_W-1:0] regWdata,
  output rxStrobes_t       strb,
  output logic             done,
  output logic             ie,
  output logic             irqReq,
  output logic             haltReq
);

  logic dataRead;
  logic statusWrite;
  logic ieNext;
  logic doneNext;
  logic irqNext;

  assign dataRead    = regRead && regAddr;
  assign statusWrite = regWrite && !regAddr;

  always_comb begin
    strb.loadChar    = charValid && !charBreak;
    strb.loadBreak   = charValid && charBreak;
    strb.flagOverrun = charValid && done && !dataRead;
    strb.clearErr    = dataRead && !charValid;
  end

  always_comb begin
    ieNext = statusWrite ? regWdata[IE_POS] : ie;

    if (charValid)     doneNext = 1'b1;
    else if (dataRead) doneNext = 1'b0;
    else               doneNext = done;

    if (charValid)        irqNext = ieNext;
    else if (dataRead)    irqNext = 1'b0;
    else if (statusWrite) begin
      if (!regWdata[IE_POS])  irqNext = 1'b0;
      else if (done && !ie)   irqNext = 1'b1;
      else                    irqNext = irqReq;
    end
    else                  irqNext = irqReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      ie      <= 1'b0;
      irqReq  <= 1'b0;
      haltReq <= 1'b0;
    end else begin
      done    <= doneNext;
      ie      <= ieNext;
      irqReq  <= irqNext;
      haltReq <= charValid && charBreak && haltEnable;
    end
  end

  // R7
  irq_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (done && ie));

  // R5
  arrival_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> done);

  // R3
  ie_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && !regWdata[IE_POS] && !charValid) |=> !irqReq);

  // R8
  halt_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(charValid && charBreak && haltEnable));

endmodule

// File: rtl/con_rx_datapath.sv
module con_rx_datapath
  import con_rx_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CHAR_W   = 8,
  parameter int DONE_POS = 7,
  parameter int IE_POS   = 6,
  parameter int ERR_POS  = 15,
  parameter int OVR_POS  = 14,
  parameter int FRM_POS  = 13,
  parameter int BRK_POS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic [CHAR_W-1:0] charData,
  input  logic              sevenBit,
  input  logic              done,
  input  logic              ie,
  input  logic              regAddr,
  output logic [REG_W-1:0]  regRdata
);

  localparam logic [REG_W-1:0] ERR_M = REG_W'(1) << ERR_POS;
  localparam logic [REG_W-1:0] OVR_M = REG_W'(1) << OVR_POS;
  localparam logic [REG_W-1:0] FRM_M = REG_W'(1) << FRM_POS;
  localparam logic [REG_W-1:0] BRK_M = REG_W'(1) << BRK_POS;
  localparam logic [REG_W-1:0] LOW_M = {{(REG_W-CHAR_W){1'b0}}, {CHAR_W{1'b1}}};
  localparam logic [CHAR_W-1:0] NARROW_M = {1'b0, {(CHAR_W-1){1'b1}}};

  logic [REG_W-1:0]  bufWord;
  logic [REG_W-1:0]  nextWord;
  logic [REG_W-1:0]  statusWord;
  logic [CHAR_W-1:0] charMask;

  assign charMask = sevenBit ? NARROW_M : {CHAR_W{1'b1}};

  always_comb begin
    nextWord = '0;
    if (strb.loadBreak) nextWord = ERR_M | FRM_M | BRK_M;
    else                nextWord[CHAR_W-1:0] = charData & charMask;
    if (strb.flagOverrun) nextWord = nextWord | ERR_M | OVR_M;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 bufWord <= '0;
    else if (strb.loadChar || strb.loadBreak)  bufWord <= nextWord;
    else if (strb.clearErr)                    bufWord <= bufWord & LOW_M;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[DONE_POS] = done;
    statusWord[IE_POS]   = ie;
  end

  assign regRdata = regAddr ? bufWord : statusWord;

  // R7
  clear_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearErr |=> (bufWord[REG_W-1:CHAR_W] == '0));

  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagOverrun |=> (bufWord[ERR_POS] && bufWord[OVR_POS]));

  // R8
  break_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBreak |=> (bufWord[ERR_POS] && bufWord[FRM_POS] && bufWord[BRK_POS]
                        && bufWord[CHAR_W-1:0] == '0));

endmodule

// File: rtl/console_rx_regs.sv
module console_rx_regs
  import con_rx_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CHAR_W   = 8,
  parameter int DONE_POS = 7,
  parameter int IE_POS   = 6,
  parameter int ERR_POS  = 15,
  parameter int OVR_POS  = 14,
  parameter int FRM_POS  = 13,
  parameter int BRK_POS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [CHAR_W-1:0] charData,
  input  logic              charBreak,
  input  logic              sevenBit,
  input  logic              haltEnable,
  input  logic              regAddr,
  input  logic              regRead,
  input  logic              regWrite,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irqReq,
  output logic              haltReq
);

  rxStrobes_t strb;
  logic       done;
  logic       ie;

  con_rx_ctrl #(
    .REG_W (REG_W),
    .IE_POS(IE_POS)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .charValid (charValid),
    .charBreak (charBreak),
    .haltEnable(haltEnable),
    .regAddr   (regAddr),
    .regRead   (regRead),
    .regWrite  (regWrite),
    .regWdata  (regWdata),
    .strb      (strb),
    .done      (done),
    .ie        (ie),
    .irqReq    (irqReq),
    .haltReq   (haltReq)
  );

  con_rx_datapath #(
    .REG_W   (REG_W),
    .CHAR_W  (CHAR_W),
    .DONE_POS(DONE_POS),
    .IE_POS  (IE_POS),
    .ERR_POS (ERR_POS),
    .OVR_POS (OVR_POS),
    .FRM_POS (FRM_POS),
    .BRK_POS (BRK_POS)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .charData (charData),
    .sevenBit (sevenBit),
    .done     (done),
    .ie       (ie),
    .regAddr  (regAddr),
    .regRdata (regRdata)
  );

endmodule

// File: tb/console_rx_regs_test.sv
module console_rx_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        charValid = 1'b0;
  logic [7:0]  charData = '0;
  logic        charBreak = 1'b0;
  logic        sevenBit = 1'b0;
  logic        haltEnable = 1'b0;
  logic        regAddr = 1'b0;
  logic        regRead = 1'b0;
  logic        regWrite = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqReq;
  logic        haltReq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  console_rx_regs uut (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charBreak(charBreak), .sevenBit(sevenBit), .haltEnable(haltEnable),
    .regAddr(regAddr), .regRead(regRead), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq), .haltReq(haltReq)
  );

  // {sevenBit, input char, expected data word}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h41, 16'h0041}, {1'b1, 8'hC1, 16'h0041},
    {1'b0, 8'hFF, 16'h00FF}, {1'b1, 8'hFF, 16'h007F},
    {1'b0, 8'h00, 16'h0000}, {1'b1, 8'h80, 16'h0000},
    {1'b0, 8'h5A, 16'h005A}, {1'b0, 8'h80, 16'h0080}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pushChar(input logic [7:0] c, input logic seven, input logic brk);
    charValid = 1'b1; charData = c; sevenBit = seven; charBreak = brk;
    @(negedge clk);
    charValid = 1'b0; charBreak = 1'b0;
  endtask

  task automatic writeStatus(input logic [15:0] w);
    regAddr = 1'b0; regWrite = 1'b1; regWdata = w;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [15:0] v);
    regAddr = a; regRead = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(1'b0, v); check("R1 status", v, 16'h0000);
    readReg(1'b1, v); check("R1 data", v, 16'h0000);
    check("R1 irq", {15'd0, irqReq}, 16'd0);
    check("R1 halt", {15'd0, haltReq}, 16'd0);

    // R2 only enable is writable, other bits ignored
    writeStatus(16'hFFBF);
    readReg(1'b0, v); check("R2 ignored bits", v, 16'h0000);
    writeStatus(16'h0040);
    readReg(1'b0, v); check("R2 enable only", v, 16'h0040);
    writeStatus(16'h0000);

    // R6 R10 table of characters, interrupts off
    foreach (VEC[i]) begin
      pushChar(VEC[i][23:16], VEC[i][24], 1'b0);
      readReg(1'b0, v); check("R5 ready set", v, 16'h0080);
      readReg(1'b1, v); check("R6 R10 data word", v, VEC[i][15:0]);
      readReg(1'b0, v); check("R7 ready cleared", v, 16'h0000);
      check("R5 no irq when disabled", {15'd0, irqReq}, 16'd0);
    end

    // R5 R3 R4 R7 interrupt rules
    writeStatus(16'h0040);
    pushChar(8'h41, 1'b0, 1'b0);
    check("R5 irq on arrival", {15'd0, irqReq}, 16'd1);
    writeStatus(16'h0000);
    check("R3 irq dropped", {15'd0, irqReq}, 16'd0);
    readReg(1'b0, v); check("R3 ready kept", v, 16'h0080);
    writeStatus(16'h0040);
    check("R4 irq raised at once", {15'd0, irqReq}, 16'd1);
    readReg(1'b1, v); check("R6 data", v, 16'h0041);
    check("R7 irq cleared", {15'd0, irqReq}, 16'd0);
    readReg(1'b0, v); check("R7 ready cleared", v, 16'h0040);

    // R9 overrun then R7 error clear
    pushChar(8'h11, 1'b0, 1'b0);
    pushChar(8'h22, 1'b0, 1'b0);
    readReg(1'b1, v); check("R9 overrun word", v, 16'hC022);
    readReg(1'b1, v); check("R7 errors cleared", v, 16'h0022);

    // R11 arrival during data read
    pushChar(8'h33, 1'b0, 1'b0);
    charValid = 1'b1; charData = 8'h44;
    readReg(1'b1, v); charValid = 1'b0;
    check("R11 read returns old", v, 16'h0033);
    readReg(1'b0, v); check("R11 ready stays", v, 16'h00C0);
    check("R11 irq stays", {15'd0, irqReq}, 16'd1);
    readReg(1'b1, v); check("R11 no overrun", v, 16'h0044);

    // R8 break with and without halt permission
    haltEnable = 1'b1;
    pushChar(8'h55, 1'b0, 1'b1);
    check("R8 halt pulse", {15'd0, haltReq}, 16'd1);
    @(negedge clk);
    check("R8 halt one cycle", {15'd0, haltReq}, 16'd0);
    readReg(1'b1, v); check("R8 break word", v, 16'hA400);
    haltEnable = 1'b0;
    pushChar(8'h55, 1'b0, 1'b1);
    check("R8 no halt when disabled", {15'd0, haltReq}, 16'd0);
    readReg(1'b1, v); check("R8 break word again", v, 16'hA400);
    check("R7 irq cleared after break", {15'd0, irqReq}, 16'd0);

    // R1 reset mid-run clears state
    pushChar(8'h77, 1'b0, 1'b0);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    readReg(1'b1, v); check("R1 data after reset", v, 16'h0000);
    readReg(1'b0, v); check("R1 status after reset", v, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule